// File: doc/BRIEF.md
# Sharing-Aware Shared Cache Controller

This block holds the control decisions for a last-level cache that four cores share. Each cycle it admits at most one core's access through a rotating-priority arbiter. When a fill needs room in a 32-way set, it names the way to give up. Ways whose lines are held by a single core are given up before lines that several cores use. This keeps shared data resident after it has been handed to a requester. When no unshared line exists, the choice falls back to a binary-tree pseudo-LRU order.

One 31-bit tree per set records recency. Every access to a way walks the tree and turns each node on the path away from that way. A lookup presents a set index with a valid bit and a shared bit for each way. One cycle later the block returns the chosen way. Data arrays, tag matching and coherence tracking live elsewhere. Lines are 64 bytes, but only way and set indices pass through this block.

Top module: `llc_share_ctrl`

## Requirements
- R1: `grant` has at most one bit set. A set bit is always one whose `req` bit is set in the same cycle. While any `req` bit is high, exactly one grant is given in that same cycle.
- R2: The search for a grant starts at the priority core and goes upward, wrapping from core 3 to core 0. After reset the priority core is core 0. After a grant to core k, core k+1 (mod 4) becomes the priority core.
- R3: With `req` all zero, `grant` is all zero and the priority core is left unchanged.
- R4: If any `lk_way_valid` bit is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the shared bits are.
- R5: If every way is valid and at least one way has `lk_way_shared` = 0, the victim is found by a masked tree walk. The walk starts at node 0, where the children of node n are 2n+1 and 2n+2. At each node it follows the side the node bit points to (0 = child 2n+1, 1 = child 2n+2) if that subtree holds an unshared way, and the other side otherwise. Leaf node 31+w is way w.
- R6: If every way is valid and shared, the victim is the plain tree walk that follows every node bit.
- R7: All tree bits of every set are 0 after reset, so the plain victim is way 0. An access to way w on `upd_*` updates every node on w's path. Each node is set to 1 when w lies under child 2n+1, and to 0 when w lies under child 2n+2. For example, after reset, an access to way 0 makes the plain victim way 16.
- R8: `vic_valid` is high in the cycle after `lk_valid` and low otherwise. `vic_way` holds the result from that lookup. A lookup sees the tree as it stood before an update presented in the same cycle.
- R9: An update changes only the tree of `upd_set`. Victims of other sets are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Per-core access request |
| grant | output | 4 | Per-core grant, one-hot or zero |
| lk_valid | input | 1 | Victim lookup strobe |
| lk_set | input | 4 | Set index for the lookup |
| lk_way_valid | input | 32 | Per-way line valid bit of the looked-up set |
| lk_way_shared | input | 32 | Per-way line shared bit of the looked-up set |
| upd_valid | input | 1 | Access strobe that updates recency |
| upd_set | input | 4 | Set index of the access |
| upd_way | input | 5 | Way index of the access |
| vic_valid | output | 1 | Victim result strobe |
| vic_way | output | 5 | Chosen victim way |

## Verification
The assertions assume that `rst_n` is low at the start and that every input is driven to a known value once reset is released. They also assume that `upd_way` and both set indices stay within the configured way and set counts. They place no limit on request patterns or on which ways are valid or shared. The bench drives every input on the falling clock edge and keeps indices within range. It covers idle request cycles, lookups on sets with no unshared ways, and lookups that coincide with an update. These are the cases where the properties on grant rotation and on victim selection matter.

// File: rtl/llc_share_pkg.sv
package llc_share_pkg;
   // Which rule produced the victim of a lookup
   typedef enum logic [1:0] {
      SRC_INVALID  = 2'd0,
      SRC_UNSHARED = 2'd1,
      SRC_PLRU     = 2'd2
   } vic_src_e;
endpackage

// File: rtl/llc_rr_arbiter.sv
module llc_rr_arbiter #(
   parameter int N_REQ = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] grant
);
   localparam int PTR_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

   initial begin
      assert (N_REQ >= 2) else $error("llc_rr_arbiter: N_REQ must be at least 2");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] win_idx;
   logic             win_any;

   // Scan from the priority core upward with wrap-around
   always_comb begin
      grant   = '0;
      win_idx = '0;
      win_any = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         int idx;
         idx = (int'(ptr_q) + i) % N_REQ;
         if (!win_any && req[idx]) begin
            win_any = 1'b1;
            win_idx = PTR_W'(idx);
         end
      end
      if (win_any && rst_n) grant[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (win_any) begin
         ptr_q <= (int'(win_idx) == N_REQ - 1) ? '0 : win_idx + PTR_W'(1);
      end
   end

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   p_grant_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0);
   p_grant_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> (grant != '0));
   p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((&req) && ($past(grant) != '0)) |->
         (grant == {$past(grant[N_REQ-2:0]), $past(grant[N_REQ-1])}));
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> $stable(ptr_q));
endmodule

// File: rtl/llc_plru_store.sv
module llc_plru_store #(
   parameter int N_SETS = 16,
   parameter int N_WAYS = 32,
   localparam int LVL   = $clog2(N_WAYS),
   localparam int SET_W = (N_SETS > 1) ? $clog2(N_SETS) : 1,
   localparam int TBITS = N_WAYS - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [TBITS-1:0] rd_tree,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [LVL-1:0]   wr_way
);
   initial begin
      assert (N_WAYS >= 4 && (N_WAYS & (N_WAYS - 1)) == 0)
         else $error("llc_plru_store: N_WAYS must be a power of two, at least 4");
   end

   logic [TBITS-1:0] tree_q [N_SETS];

   // Turn every node on the path of w away from w
   function automatic logic [TBITS-1:0] touch(input logic [TBITS-1:0] t,
                                              input logic [LVL-1:0]   w);
      logic [TBITS-1:0] r;
      logic [LVL-1:0]   node;
      r    = t;
      node = '0;
      for (int lv = 0; lv < LVL; lv++) begin
         logic b;
         b       = w[LVL-1-lv];
         r[node] = ~b;
         node    = {node[LVL-2:0], b} + LVL'(1);
      end
      return r;
   endfunction

   assign rd_tree = tree_q[rd_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < N_SETS; s++) tree_q[s] <= '0;
      end else if (wr_en) begin
         tree_q[wr_set] <= touch(tree_q[wr_set], wr_way);
      end
   end

   p_root_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (tree_q[$past(wr_set)][0] == !$past(wr_way[LVL-1])));
endmodule

// File: rtl/llc_plru_walk.sv
module llc_plru_walk #(
   parameter int N_WAYS = 32,
   localparam int LVL    = $clog2(N_WAYS),
   localparam int NODES  = 2 * N_WAYS - 1,
   localparam int NODE_W = LVL + 1
) (
   input  logic [N_WAYS-2:0] tree,
   input  logic [N_WAYS-1:0] cand,
   output logic [LVL-1:0]    way
);
   logic [NODES-1:0]  has;
   logic [NODE_W-1:0] node;
   logic [NODE_W-1:0] leaf;

   // has[n]: subtree under node n contains a candidate way
   always_comb begin
      has = '0;
      for (int w = 0; w < N_WAYS; w++) has[N_WAYS-1+w] = cand[w];
      for (int n = N_WAYS - 2; n >= 0; n--) has[n] = has[2*n+1] | has[2*n+2];
   end

   // Follow each node bit unless that side has no candidate
   always_comb begin
      node = '0;
      for (int lv = 0; lv < LVL; lv++) begin
         logic [NODE_W-1:0] lc;
         logic [NODE_W-1:0] rc;
         lc = {node[NODE_W-2:0], 1'b1};
         rc = {node[NODE_W-2:0], 1'b0} + NODE_W'(2);
         if (tree[node[LVL-1:0]]) node = has[rc] ? rc : lc;
         else                     node = has[lc] ? lc : rc;
      end
      leaf = node - NODE_W'(N_WAYS - 1);
      way  = leaf[LVL-1:0];
   end
endmodule

// File: rtl/llc_share_ctrl.sv
module llc_share_ctrl #(
   parameter int N_REQ  = 4,
   parameter int N_SETS = 16,
   parameter int N_WAYS = 32,
   localparam int WAY_W = $clog2(N_WAYS),
   localparam int SET_W = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  req,
   output logic [N_REQ-1:0]  grant,
   input  logic              lk_valid,
   input  logic [SET_W-1:0]  lk_set,
   input  logic [N_WAYS-1:0] lk_way_valid,
   input  logic [N_WAYS-1:0] lk_way_shared,
   input  logic              upd_valid,
   input  logic [SET_W-1:0]  upd_set,
   input  logic [WAY_W-1:0]  upd_way,
   output logic              vic_valid,
   output logic [WAY_W-1:0]  vic_way
);
   import llc_share_pkg::*;

   initial begin
      assert (N_WAYS >= 4 && (N_WAYS & (N_WAYS - 1)) == 0)
         else $error("llc_share_ctrl: N_WAYS must be a power of two, at least 4");
      assert (N_SETS >= 1) else $error("llc_share_ctrl: N_SETS must be positive");
   end

   llc_rr_arbiter #(.N_REQ(N_REQ)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
   );

   logic [N_WAYS-2:0] set_tree;

   llc_plru_store #(.N_SETS(N_SETS), .N_WAYS(N_WAYS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_set(lk_set), .rd_tree(set_tree),
      .wr_en(upd_valid), .wr_set(upd_set), .wr_way(upd_way)
   );

   logic [N_WAYS-1:0] unshared;
   logic [N_WAYS-1:0] cand;
   logic [WAY_W-1:0]  walk_way;
   logic [WAY_W-1:0]  inv_way;
   logic [WAY_W-1:0]  pick_way;
   vic_src_e          src;

   assign unshared = lk_way_valid & ~lk_way_shared;
   assign cand     = (unshared != '0) ? unshared : '1;

   llc_plru_walk #(.N_WAYS(N_WAYS)) u_walk (
      .tree(set_tree), .cand(cand), .way(walk_way)
   );

   // Lowest-numbered invalid way
   always_comb begin
      inv_way = '0;
      for (int w = N_WAYS - 1; w >= 0; w--)
         if (!lk_way_valid[w]) inv_way = WAY_W'(w);
   end

   always_comb begin
      if (lk_way_valid != '1)  src = SRC_INVALID;
      else if (unshared != '0) src = SRC_UNSHARED;
      else                     src = SRC_PLRU;
      pick_way = (src == SRC_INVALID) ? inv_way : walk_way;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vic_valid <= 1'b0;
         vic_way   <= '0;
      end else begin
         vic_valid <= lk_valid;
         if (lk_valid) vic_way <= pick_way;
      end
   end

   p_invalid_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && (lk_way_valid != '1)) |=> !(($past(lk_way_valid) >> vic_way) & 1));
   p_unshared_pref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && (lk_way_valid == '1) && (lk_way_shared != '1)) |=>
         !(($past(lk_way_shared) >> vic_way) & 1));
   p_walk_in_cand_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> cand[walk_way]);
   p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid == $past(lk_valid));
endmodule

// File: tb/llc_share_ctrl_bench.sv
module llc_share_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req = '0;
   logic [3:0]  grant;
   logic        lk_valid = 1'b0;
   logic [3:0]  lk_set = '0;
   logic [31:0] lk_way_valid = '0;
   logic [31:0] lk_way_shared = '0;
   logic        upd_valid = 1'b0;
   logic [3:0]  upd_set = '0;
   logic [4:0]  upd_way = '0;
   logic        vic_valid;
   logic [4:0]  vic_way;

   int checks = 0;
   int errors = 0;
   int ptr_m  = 0;
   logic [30:0] tree_m [16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   llc_share_ctrl u_llc_share_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
      .lk_valid(lk_valid), .lk_set(lk_set),
      .lk_way_valid(lk_way_valid), .lk_way_shared(lk_way_shared),
      .upd_valid(upd_valid), .upd_set(upd_set), .upd_way(upd_way),
      .vic_valid(vic_valid), .vic_way(vic_way)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Reference model built from the requirement text
   function automatic bit sub_has(input logic [31:0] c, input int node);
      int lv = 0, first = 0, k, size;
      while (node > first + (1 << lv) - 1) begin
         first = first + (1 << lv);
         lv++;
      end
      k    = node - first;
      size = 32 >> lv;
      for (int i = 0; i < size; i++) if (c[k * size + i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int m_walk(input logic [30:0] t, input logic [31:0] c);
      int node = 0;
      for (int lv = 0; lv < 5; lv++) begin
         int pref, alt;
         pref = t[node] ? 2 * node + 2 : 2 * node + 1;
         alt  = t[node] ? 2 * node + 1 : 2 * node + 2;
         node = sub_has(c, pref) ? pref : alt;
      end
      return node - 31;
   endfunction

   function automatic logic [30:0] m_touch(input logic [30:0] t, input int w);
      int node = 0;
      for (int lv = 0; lv < 5; lv++) begin
         int b;
         b = (w >> (4 - lv)) & 1;
         t[node] = (b == 0);
         node = 2 * node + 1 + b;
      end
      return t;
   endfunction

   function automatic int m_expect(input int s, input logic [31:0] v, input logic [31:0] sh);
      logic [31:0] un;
      for (int w = 0; w < 32; w++) if (!v[w]) return w;
      un = v & ~sh;
      return m_walk(tree_m[s], (un != 0) ? un : 32'hFFFF_FFFF);
   endfunction

   task automatic arb_step(input logic [3:0] r, input string tag);
      int exp_idx = -1;
      logic [3:0] exp_g = '0;
      @(negedge clk);
      req = r;
      #1;
      for (int i = 0; i < 4; i++) begin
         int idx;
         idx = (ptr_m + i) % 4;
         if (exp_idx < 0 && r[idx]) exp_idx = idx;
      end
      if (exp_idx >= 0) begin
         exp_g[exp_idx] = 1'b1;
         ptr_m = (exp_idx + 1) % 4;
      end
      chk(grant == exp_g, tag, grant, exp_g);
   endtask

   task automatic access(input int s, input int w);
      @(negedge clk);
      upd_valid = 1'b1; upd_set = 4'(s); upd_way = 5'(w);
      @(negedge clk);
      upd_valid = 1'b0;
      tree_m[s] = m_touch(tree_m[s], w);
   endtask

   task automatic lookup(input int s, input logic [31:0] v, input logic [31:0] sh,
                         input string tag);
      int exp;
      exp = m_expect(s, v, sh);
      @(negedge clk);
      lk_valid = 1'b1; lk_set = 4'(s); lk_way_valid = v; lk_way_shared = sh;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(vic_valid == 1'b1, {tag, " strobe R8"}, vic_valid, 1);
      chk(vic_way == 5'(exp), tag, vic_way, exp);
   endtask

   task automatic t_reset;
      chk(grant == 4'b0 && vic_valid == 1'b0, "R3 reset outputs idle", grant, 0);
      lookup(0, '1, '1, "R7 reset plain victim way 0");
      @(negedge clk);
      chk(vic_valid == 1'b0, "R8 strobe drops", vic_valid, 0);
   endtask

   task automatic t_arb_rotate;
      for (int i = 0; i < 8; i++) arb_step(4'b1111, "R2 full rotation");
   endtask

   task automatic t_arb_sparse;
      arb_step(4'b1010, "R2 sparse");
      arb_step(4'b0000, "R3 idle no grant");
      arb_step(4'b0000, "R3 idle no grant");
      arb_step(4'b1010, "R3 pointer held over idle");
      arb_step(4'b0001, "R1 single requester");
      arb_step(4'b0100, "R1 single requester");
      arb_step(4'b1001, "R2 wrap");
      arb_step(4'b0110, "R2 mixed");
      arb_step(4'b0000, "R3 idle");
   endtask

   task automatic t_plru;
      access(0, 0);
      lookup(0, '1, '1, "R7 after way 0 victim 16");
      chk(vic_way == 5'd16, "R7 hand value 16", vic_way, 16);
      access(0, 16);
      lookup(0, '1, '1, "R6 after way 16");
      chk(vic_way == 5'd8, "R7 hand value 8", vic_way, 8);
      for (int i = 0; i < 10; i++) access(0, (i * 7 + 3) % 32);
      lookup(0, '1, '1, "R6 plain victim after mix");
   endtask

   task automatic t_invalid;
      lookup(0, 32'hFFFF_FF00 | 32'h0000_00F7, 32'h0, "R4 single invalid way 3");
      lookup(0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R4 invalid over shared");
      lookup(0, 32'h0, 32'h0, "R4 all invalid");
   endtask

   task automatic t_unshared;
      lookup(0, '1, 32'hFFFF_FFFE, "R5 only way 0 unshared");
      lookup(0, '1, 32'h7FFF_FFFF, "R5 only way 31 unshared");
      lookup(0, '1, 32'h0F0F_F0F0, "R5 mixed mask");
      lookup(0, '1, 32'h0000_0000, "R5 none shared");
      lookup(0, '1, 32'hAAAA_5555, "R5 alternating mask");
   endtask

   task automatic t_same_cycle;
      int exp;
      exp = m_expect(2, '1, '1);
      @(negedge clk);
      lk_valid = 1'b1; lk_set = 4'd2; lk_way_valid = '1; lk_way_shared = '1;
      upd_valid = 1'b1; upd_set = 4'd2; upd_way = 5'(exp);
      @(negedge clk);
      lk_valid = 1'b0; upd_valid = 1'b0;
      tree_m[2] = m_touch(tree_m[2], exp);
      chk(vic_way == 5'(exp), "R8 lookup sees pre-update tree", vic_way, exp);
      lookup(2, '1, '1, "R8 update visible next lookup");
   endtask

   task automatic t_set_indep;
      lookup(5, '1, '1, "R9 set 5 before");
      access(3, 0);
      access(3, 9);
      lookup(5, '1, '1, "R9 set 5 unchanged");
      lookup(3, '1, '1, "R9 set 3 changed");
   endtask

   initial begin
      for (int s = 0; s < 16; s++) tree_m[s] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_arb_rotate;
      t_arb_sparse;
      t_plru;
      t_invalid;
      t_unshared;
      t_same_cycle;
      t_set_indep;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule